// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block is the digital decision core of a secondary-side synchronous rectifier controller in a flyback converter. Three comparator flags derived from the drain-source voltage of the rectifier transistor arrive asynchronously: a turn-on flag (VDS well below zero, body diode conducting), a turn-off flag (VDS risen above a small negative level, current nearly zero) and a reset flag (VDS positive, the winding has reversed). From these it produces a single gate-drive request, so that the transistor behaves like a diode with a much lower drop.

Two independent masking windows protect the gate. The minimum-on window hides the turn-off flag for a programmable cycle count just after turn-on, so that ringing cannot end conduction early. The post-turn-off blanking window hides the turn-on flag for a fixed interval after turn-off, so that residual body-diode current cannot retrigger the gate. A positive reset flag ends that window early, which is how fast continuous-conduction turn-offs are followed by a prompt next cycle. A supply/enable state machine with hysteresis gates everything: the gate can be driven only in the normal power state.

Power states (mode_o): POWERON (2'b00, held in reset), SLEEP (2'b01, undervoltage or disabled), NORMAL (2'b10). Transitions: POWERON to NORMAL or SLEEP on the first edge after reset; SLEEP to NORMAL when the supply is above the turn-on level and enable is high; NORMAL to SLEEP when the supply is below the lockout level or enable is low. Gate states: IDLE, MINON (gate on, turn-off masked), CONDUCT (gate on, turn-off watched), BLANK (gate off, turn-on masked). Transitions: IDLE to MINON on the turn-on flag; MINON to CONDUCT when the minimum-on count expires; CONDUCT to BLANK on the turn-off flag; BLANK to IDLE when the blanking count expires or on the reset flag; any gate state to IDLE when the power state is leaving or outside NORMAL.

Top module: `sr_gate_sequencer`

## Requirements
- R1: While rst_n is low, gate_o is 0 and mode_o is POWERON (2'b00); on the first clock edge after release with the entry condition false, mode_o becomes SLEEP (2'b01).
- R2: From POWERON or SLEEP, mode_o becomes NORMAL (2'b10) on the first edge at which sup_above_on_i and enable_i are both 1, and stays out of NORMAL while either is 0.
- R3: In NORMAL, mode_o becomes SLEEP on the first edge at which sup_below_off_i is 1 or enable_i is 0; sup_above_on_i falling to 0 alone does not leave NORMAL (hysteresis band).
- R4: gate_o is 0 whenever mode_o is not NORMAL, whatever the comparator flags do.
- R5: Each raw flag passes two synchronizer flops: a turn-on flag first sampled high at edge n in IDLE raises gate_o and minon_win_o after edge n+2.
- R6: For max(M,1) cycles after turn-on, where M is min_on_cyc_i sampled at the turn-on edge, minon_win_o is 1 and the turn-off flag is ignored; changing min_on_cyc_i afterwards has no effect on that pulse.
- R7: After the minimum-on window, gate_o stays 1 while the turn-off flag is low, and falls after edge n+2 when the turn-off flag is first sampled high at edge n.
- R8: Turn-off starts a blanking window of BLANK_CYC cycles with blank_win_o at 1; a turn-on flag during the window is dropped, not queued, so gate_o stays 0 when the window ends if the flag has cleared.
- R9: A reset flag first sampled high at edge n during blanking ends the window after edge n+2, after which a turn-on flag is accepted again.
- R10: Leaving NORMAL forces gate_o, minon_win_o and blank_win_o to 0 on the same edge at which mode_o leaves NORMAL.
- R11: In IDLE the turn-off and reset flags have no effect: gate_o, minon_win_o and blank_win_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_above_on_i | input | 1 | Supply is above the turn-on level |
| sup_below_off_i | input | 1 | Supply is below the lockout level |
| enable_i | input | 1 | Enable; low selects sleep |
| vds_on_raw_i | input | 1 | Asynchronous turn-on comparator flag |
| vds_off_raw_i | input | 1 | Asynchronous turn-off comparator flag |
| vds_rst_raw_i | input | 1 | Asynchronous positive reset comparator flag |
| min_on_cyc_i | input | MOT_W | Minimum on-time in clock cycles |
| gate_o | output | 1 | Gate-drive request |
| mode_o | output | 2 | Power state: 00 POWERON, 01 SLEEP, 10 NORMAL |
| minon_win_o | output | 1 | Minimum-on window active |
| blank_win_o | output | 1 | Post-turn-off blanking window active |

## Verification
A wrong gate state shows at gate_o and the two window outputs within one clock of the synchronized flag, so checks sample exactly two edges after the flag is first captured and a one-cycle slip in either window length is caught as a mismatch at the boundary sample. A timer that fails to clear or a state that does not return to IDLE shows up later, as a turn-on that is refused or a blank window that stays high when the next pulse arrives. Power-state faults show directly on mode_o one edge after the supply or enable change, and a gate that leaks outside NORMAL is visible on gate_o during sleep.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;

    typedef enum logic [1:0] {
        PWR_POWERON = 2'b00,
        PWR_SLEEP   = 2'b01,
        PWR_NORMAL  = 2'b10
    } pwr_state_t;

    typedef enum logic [1:0] {
        GS_IDLE    = 2'b00,
        GS_MINON   = 2'b01,
        GS_CONDUCT = 2'b10,
        GS_BLANK   = 2'b11
    } gate_state_t;

    localparam int NUM_FLAGS = 3;
    localparam int FLAG_ON   = 0;
    localparam int FLAG_OFF  = 1;
    localparam int FLAG_RST  = 2;

endpackage

// File: rtl/sr_flag_sync.sv
module sr_flag_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], d_i[i]};
                end
            end
            assign q_o[i] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sr_down_timer.sv
module sr_down_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] cnt_o,
    output logic         last_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q <= W'(1));

endmodule

// File: rtl/sr_power_fsm.sv
module sr_power_fsm
    import sr_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sup_above_on_i,
    input  logic       sup_below_off_i,
    input  logic       enable_i,
    output pwr_state_t state_o,
    output logic       run_nxt_o
);

    pwr_state_t state_q, state_d;
    logic       go_up, go_down;

    assign go_up   = sup_above_on_i && enable_i;
    assign go_down = sup_below_off_i || !enable_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_POWERON: state_d = go_up ? PWR_NORMAL : PWR_SLEEP;
            PWR_SLEEP:   state_d = go_up ? PWR_NORMAL : PWR_SLEEP;
            PWR_NORMAL:  state_d = go_down ? PWR_SLEEP : PWR_NORMAL;
            default:     state_d = PWR_SLEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PWR_POWERON;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o   = state_q;
    assign run_nxt_o = (state_d == PWR_NORMAL);

    // R3: lockout or disable leaves NORMAL on the next edge
    a_r3_exit_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_NORMAL && go_down) |=> (state_q == PWR_SLEEP));

    // R3: supply in the hysteresis band keeps NORMAL
    a_r3_hysteresis_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_NORMAL && !sup_below_off_i && enable_i) |=> (state_q == PWR_NORMAL));

    // R2: NORMAL cannot be entered without supply-on and enable
    a_r2_entry_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PWR_NORMAL && !go_up) |=> (state_q != PWR_NORMAL));

endmodule

// File: rtl/sr_gate_fsm.sv
module sr_gate_fsm
    import sr_gate_pkg::*;
#(
    parameter int MOT_W     = 8,
    parameter int BLANK_CYC = 750
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             on_s_i,
    input  logic             off_s_i,
    input  logic             rst_s_i,
    input  logic [MOT_W-1:0] min_on_cyc_i,
    output logic             gate_o,
    output logic             minon_o,
    output logic             blank_o
);

    localparam int BLK_W = $clog2(BLANK_CYC + 1);

    gate_state_t state_q, state_d;

    logic             mot_load, mot_last;
    logic [MOT_W-1:0] mot_cnt;
    logic             blk_load, blk_last;
    logic [BLK_W-1:0] blk_cnt;

    always_comb begin
        state_d = state_q;
        if (!run_i) begin
            state_d = GS_IDLE;
        end else begin
            unique case (state_q)
                GS_IDLE:    if (on_s_i)   state_d = GS_MINON;
                GS_MINON:   if (mot_last) state_d = GS_CONDUCT;
                GS_CONDUCT: if (off_s_i)  state_d = GS_BLANK;
                GS_BLANK:   if (rst_s_i || blk_last) state_d = GS_IDLE;
            endcase
        end
    end

    assign mot_load = (state_q == GS_IDLE)    && (state_d == GS_MINON);
    assign blk_load = (state_q == GS_CONDUCT) && (state_d == GS_BLANK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        gate_o  = 1'b0;
        minon_o = 1'b0;
        blank_o = 1'b0;
        unique case (state_q)
            GS_IDLE:    ;
            GS_MINON:   begin gate_o = 1'b1; minon_o = 1'b1; end
            GS_CONDUCT: gate_o  = 1'b1;
            GS_BLANK:   blank_o = 1'b1;
        endcase
    end

    sr_down_timer #(.W(MOT_W)) u_mot_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!run_i),
        .load_i (mot_load),
        .val_i  (min_on_cyc_i),
        .cnt_o  (mot_cnt),
        .last_o (mot_last)
    );

    sr_down_timer #(.W(BLK_W)) u_blk_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!run_i),
        .load_i (blk_load),
        .val_i  (BLK_W'(BLANK_CYC)),
        .cnt_o  (blk_cnt),
        .last_o (blk_last)
    );

    // R10: leaving NORMAL parks the sequencer and empties both timers
    a_r10_leave_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (state_q == GS_IDLE && mot_cnt == '0 && blk_cnt == '0));

    // R6: the gate cannot fall before the minimum-on count runs out
    a_r6_minon_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_MINON && !mot_last && run_i) |=> (gate_o && minon_o));

    // R7: conduction continues while the turn-off flag stays low
    a_r7_conduct_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_CONDUCT && !off_s_i && run_i) |=> gate_o);

    // R8: no turn-on while blanking is still running
    a_r8_blank_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_BLANK && !rst_s_i && !blk_last && run_i) |=> (!gate_o && blank_o));

    // R9: reset flag ends blanking at once
    a_r9_reset_ends_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_BLANK && rst_s_i) |=> (state_q == GS_IDLE));

    // R11: idle without a turn-on flag stays idle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_IDLE && !on_s_i) |=> (!gate_o && !blank_o && !minon_o));

endmodule

// File: rtl/sr_gate_sequencer.sv
module sr_gate_sequencer
    import sr_gate_pkg::*;
#(
    parameter int MOT_W       = 8,
    parameter int BLANK_CYC   = 750,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sup_above_on_i,
    input  logic             sup_below_off_i,
    input  logic             enable_i,
    input  logic             vds_on_raw_i,
    input  logic             vds_off_raw_i,
    input  logic             vds_rst_raw_i,
    input  logic [MOT_W-1:0] min_on_cyc_i,
    output logic             gate_o,
    output logic [1:0]       mode_o,
    output logic             minon_win_o,
    output logic             blank_win_o
);

    logic [NUM_FLAGS-1:0] raw_flags, sync_flags;
    pwr_state_t           pwr_state;
    logic                 run_nxt;

    assign raw_flags[FLAG_ON]  = vds_on_raw_i;
    assign raw_flags[FLAG_OFF] = vds_off_raw_i;
    assign raw_flags[FLAG_RST] = vds_rst_raw_i;

    sr_flag_sync #(.N(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_flags),
        .q_o   (sync_flags)
    );

    sr_power_fsm u_pwr (
        .clk             (clk),
        .rst_n           (rst_n),
        .sup_above_on_i  (sup_above_on_i),
        .sup_below_off_i (sup_below_off_i),
        .enable_i        (enable_i),
        .state_o         (pwr_state),
        .run_nxt_o       (run_nxt)
    );

    sr_gate_fsm #(.MOT_W(MOT_W), .BLANK_CYC(BLANK_CYC)) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run_nxt),
        .on_s_i       (sync_flags[FLAG_ON]),
        .off_s_i      (sync_flags[FLAG_OFF]),
        .rst_s_i      (sync_flags[FLAG_RST]),
        .min_on_cyc_i (min_on_cyc_i),
        .gate_o       (gate_o),
        .minon_o      (minon_win_o),
        .blank_o      (blank_win_o)
    );

    assign mode_o = pwr_state;

    // R4: the gate is only ever requested in NORMAL
    a_r4_gate_only_normal: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> (mode_o == 2'b10));

    // R10: no window stays open outside NORMAL
    a_r10_windows_only_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (minon_win_o || blank_win_o) |-> (mode_o == 2'b10));

endmodule

// File: tb/sr_gate_sequencer_tb.sv
module sr_gate_sequencer_tb;

    localparam int MOT_W = 8;
    localparam int BLK   = 40;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             above_on, below_off, en;
    logic             f_on, f_off, f_rst;
    logic [MOT_W-1:0] mot;
    logic             gate, minon, blank;
    logic [1:0]       mode;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    sr_gate_sequencer #(.MOT_W(MOT_W), .BLANK_CYC(BLK)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .sup_above_on_i  (above_on),
        .sup_below_off_i (below_off),
        .enable_i        (en),
        .vds_on_raw_i    (f_on),
        .vds_off_raw_i   (f_off),
        .vds_rst_raw_i   (f_rst),
        .min_on_cyc_i    (mot),
        .gate_o          (gate),
        .mode_o          (mode),
        .minon_win_o     (minon),
        .blank_win_o     (blank)
    );

    // {req[3:0], on, off, rst, wait[7:0], gate, minon, blank}; MOT = 5, BLK = 40
    localparam int NV = 19;
    localparam logic [17:0] VEC [NV] = '{
        {4'd11, 1'b0, 1'b0, 1'b0, 8'd3,  1'b0, 1'b0, 1'b0}, // R11 idle quiet
        {4'd5,  1'b1, 1'b0, 1'b0, 8'd2,  1'b0, 1'b0, 1'b0}, // R5 still in synchronizer
        {4'd5,  1'b1, 1'b0, 1'b0, 8'd1,  1'b1, 1'b1, 1'b0}, // R5 gate up on third edge
        {4'd6,  1'b0, 1'b1, 1'b0, 8'd3,  1'b1, 1'b1, 1'b0}, // R6 turn-off masked
        {4'd6,  1'b0, 1'b1, 1'b0, 8'd2,  1'b1, 1'b0, 1'b0}, // R6 window of 5 ended
        {4'd7,  1'b0, 1'b1, 1'b0, 8'd1,  1'b0, 1'b0, 1'b1}, // R7 drop after window
        {4'd8,  1'b1, 1'b0, 1'b0, 8'd5,  1'b0, 1'b0, 1'b1}, // R8 retrigger masked
        {4'd8,  1'b0, 1'b0, 1'b0, 8'd5,  1'b0, 1'b0, 1'b1}, // R8 still blanking
        {4'd8,  1'b0, 1'b0, 1'b0, 8'd30, 1'b0, 1'b0, 1'b0}, // R8 window of 40 over
        {4'd8,  1'b0, 1'b0, 1'b0, 8'd4,  1'b0, 1'b0, 1'b0}, // R8 request not queued
        {4'd5,  1'b1, 1'b0, 1'b0, 8'd3,  1'b1, 1'b1, 1'b0}, // R5 second pulse
        {4'd7,  1'b0, 1'b0, 1'b0, 8'd6,  1'b1, 1'b0, 1'b0}, // R7 conducting
        {4'd7,  1'b0, 1'b0, 1'b0, 8'd10, 1'b1, 1'b0, 1'b0}, // R7 long conduction
        {4'd7,  1'b0, 1'b1, 1'b0, 8'd3,  1'b0, 1'b0, 1'b1}, // R7 turn-off
        {4'd9,  1'b0, 1'b0, 1'b1, 8'd2,  1'b0, 1'b0, 1'b1}, // R9 reset in synchronizer
        {4'd9,  1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 1'b0, 1'b0}, // R9 blanking cut short
        {4'd9,  1'b1, 1'b0, 1'b0, 8'd3,  1'b1, 1'b1, 1'b0}, // R9 next pulse accepted
        {4'd8,  1'b0, 1'b1, 1'b0, 8'd8,  1'b0, 1'b0, 1'b1}, // R8 full window start
        {4'd8,  1'b0, 1'b0, 1'b0, 8'd40, 1'b0, 1'b0, 1'b0}  // R8 full window end
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; above_on = 1'b0; below_off = 1'b1; en = 1'b0;
        f_on = 1'b0; f_off = 1'b0; f_rst = 1'b0; mot = 8'd5;
        tick(3);
        chk("R1", "gate in reset", gate, 0);
        chk("R1", "mode in reset", mode, 0);
        rst_n = 1'b1;
        tick(1);
        chk("R1", "mode after reset", mode, 1);

        // R4: flags in sleep never reach the gate
        f_on = 1'b1;
        tick(4);
        chk("R4", "gate in sleep", gate, 0);
        chk("R4", "minon in sleep", minon, 0);
        f_on = 1'b0;
        tick(3);

        // R2: entry needs both supply-on and enable
        above_on = 1'b1; below_off = 1'b0;
        tick(2);
        chk("R2", "mode without enable", mode, 1);
        en = 1'b1;
        tick(1);
        chk("R2", "mode entered", mode, 2);

        for (int i = 0; i < NV; i++) begin
            logic [17:0] v;
            v = VEC[i];
            f_on = v[13]; f_off = v[12]; f_rst = v[11];
            tick(int'(v[10:3]));
            chk($sformatf("R%0d", v[17:14]), $sformatf("vec %0d gate", i), gate, v[2]);
            chk($sformatf("R%0d", v[17:14]), $sformatf("vec %0d minon", i), minon, v[1]);
            chk($sformatf("R%0d", v[17:14]), $sformatf("vec %0d blank", i), blank, v[0]);
        end
        f_on = 1'b0; f_off = 1'b0; f_rst = 1'b0;

        // R11: turn-off and reset flags in idle
        f_off = 1'b1; f_rst = 1'b1;
        tick(5);
        chk("R11", "gate", gate, 0);
        chk("R11", "blank", blank, 0);
        chk("R11", "minon", minon, 0);
        f_off = 1'b0; f_rst = 1'b0;
        tick(3);

        // R6: minimum-on sampled at turn-on, later change ignored
        mot = 8'd10;
        f_on = 1'b1;
        tick(3);
        chk("R6", "gate up", gate, 1);
        f_on = 1'b0; mot = 8'd2;
        tick(8);
        chk("R6", "minon after 8", minon, 1);
        tick(2);
        chk("R6", "minon after 10", minon, 0);
        chk("R7", "gate conducting", gate, 1);
        f_off = 1'b1;
        tick(3);
        chk("R7", "gate off", gate, 0);
        f_off = 1'b0;
        tick(45);
        chk("R8", "blank over", blank, 0);

        // R3: hysteresis band and lockout exit
        above_on = 1'b0;
        tick(3);
        chk("R3", "mode in band", mode, 2);
        below_off = 1'b1;
        tick(1);
        chk("R3", "mode lockout", mode, 1);
        below_off = 1'b0;
        tick(3);
        chk("R2", "mode no re-entry in band", mode, 1);
        above_on = 1'b1;
        tick(1);
        chk("R2", "mode re-entered", mode, 2);

        // R10: disable during conduction
        f_on = 1'b1;
        tick(3);
        chk("R10", "gate up", gate, 1);
        f_on = 1'b0;
        tick(6);
        chk("R10", "gate conducting", gate, 1);
        en = 1'b0;
        tick(1);
        chk("R10", "gate forced low", gate, 0);
        chk("R3", "mode after disable", mode, 1);
        chk("R10", "minon cleared", minon, 0);
        tick(3);
        en = 1'b1;
        tick(1);
        chk("R2", "mode back", mode, 2);

        // R10: disable during blanking
        f_on = 1'b1;
        tick(3);
        f_on = 1'b0; f_off = 1'b1;
        tick(4);
        chk("R10", "blank before exit", blank, 1);
        en = 1'b0;
        tick(1);
        chk("R10", "blank cleared", blank, 0);
        chk("R10", "mode sleep", mode, 1);
        chk("R4", "gate sleep", gate, 0);
        f_off = 1'b0;
        tick(2);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule